// File: doc/BRIEF.md
# Framed Stream Command Decoder

This block sits on the receiving side of a 32-bit AXI4-Stream link and interprets each incoming frame as one command. A frame opens with a header word whose upper half is an opcode and whose lower half is a payload length in bytes. A whole number of 32-bit payload words follows, and `tlast` marks the final beat. The decoder counts payload beats against the declared length. It then acts on a short command table: load a channel count and a sample period, switch streaming on, or switch streaming off.

Frames are never stalled. A frame is rejected if `tlast` arrives early or late, if its length is malformed, or if any beat has a partial keep mask. A rejected frame produces a one-cycle error pulse, and the decoder re-locks on the next beat as a header. A frame that is well formed but is not a recognised command produces a one-cycle drop pulse instead. Neither kind of bad frame changes any output setting.

Top module: `frame_cmd_decoder`

## Requirements
- R1: While `rst` is high, `inReady` is low. At all other times it is high. A reset clears `chanCount`, `samplePeriod`, `streamEn`, `frameErr` and `frameDrop` to zero.
- R2: The first accepted beat of a frame is the header. Bits [31:16] are the opcode and bits [15:0] are the length in bytes. The frame carries length/4 payload beats, and the largest legal length is 1024, which is 256 beats.
- R3: A configure frame has opcode 0x0052, length 8 and exactly two payload beats. In the cycle after its final beat, `chanCount` takes bits [CHAN_W-1:0] of payload word 0 and `samplePeriod` takes bits [PERIOD_W-1:0] of payload word 1.
- R4: A header-only frame (length 0, `tlast` on the header) with opcode 0x0054 sets `streamEn` to 1 in the next cycle. With opcode 0x0055 it clears `streamEn` to 0.
- R5: Only cycles with both `inValid` and `inReady` high advance the frame. Data and `inLast` on cycles with `inValid` low have no effect.
- R6: If `tlast` comes before length/4 payload beats have been seen, `frameErr` pulses in the cycle after that beat and no setting changes. This includes `tlast` on the header when the length is non-zero.
- R7: If `tlast` has not come by the beat the length predicts, all beats up to `tlast` are consumed, `frameErr` pulses in the cycle after the `tlast` beat, and no setting changes. This includes a length of 0 with no `tlast` on the header. The beat after that `tlast` is taken as a new header.
- R8: A frame is rejected with `frameErr` at its end, and changes nothing, if its length is above 1024, if its length is not a multiple of 4, or if any of its beats has `inKeep` other than 4'hF.
- R9: A well-formed frame whose opcode is not 0x0052, 0x0054 or 0x0055 makes `frameDrop` pulse in the cycle after its `tlast` beat and changes nothing.
- R10: A well-formed configure frame with a length other than 8, or a start or stop frame with a length other than 0, makes `frameDrop` pulse and changes nothing.
- R11: `frameErr` and `frameDrop` are never high together, and each is high for exactly one cycle per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inData | input | DATA_W (32) | Stream data word |
| inKeep | input | DATA_W/8 (4) | Byte-keep mask, all ones on legal beats |
| inValid | input | 1 | Stream beat valid |
| inLast | input | 1 | Last beat of a frame |
| inReady | output | 1 | Ready to accept a beat |
| chanCount | output | CHAN_W (16) | Configured channel count |
| samplePeriod | output | PERIOD_W (32) | Configured sample period in clock ticks |
| streamEn | output | 1 | Streaming enabled |
| frameErr | output | 1 | One-cycle pulse on a misframed frame |
| frameDrop | output | 1 | One-cycle pulse on an unrecognised command |

## Verification
The bench builds the decoder with its default parameters. A 16-bit channel count lets the test see the upper half of word 0 being discarded. The 1024-byte limit keeps the largest legal frame (256 payload beats) and the smallest oversize frame (1028 bytes, 257 beats) within a short run, so the length boundary is tested from both sides. Idle gaps carrying random data and random `inLast` values are inserted between beats. Together with randomly lengthened and shortened frames, this tests the beat counter against a `tlast` that arrives off-count at every position.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef struct packed {
    logic hdrLoad;
    logic word0Load;
    logic cfgCommit;
    logic streamOn;
    logic streamOff;
    logic errPulse;
    logic dropPulse;
  } fcdStrobes_t;
endpackage

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import fcd_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int MAX_LEN_BYTES = 1024,
  parameter logic [LEN_W-1:0] OP_CONFIG = 16'h0052,
  parameter logic [LEN_W-1:0] OP_START = 16'h0054,
  parameter logic [LEN_W-1:0] OP_STOP = 16'h0055
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beatFire,
  input  logic             inLast,
  input  logic             keepOk,
  input  logic [LEN_W-1:0] hdrOp,
  input  logic [LEN_W-1:0] hdrLen,
  input  logic [LEN_W-1:0] capOp,
  input  logic [LEN_W-1:0] capLen,
  output fcdStrobes_t      st
);
  localparam int MAX_BEATS = MAX_LEN_BYTES / 4;
  localparam int BEAT_W = $clog2(MAX_BEATS + 1);

  logic inPayload;
  logic [BEAT_W-1:0] beatCnt;
  logic [BEAT_W-1:0] expBeats;
  logic badQ;

  logic [BEAT_W:0] cntNext;
  logic over;
  logic badNext;
  logic lenOk;
  logic frameEnd;
  logic frameOk;
  logic [LEN_W-1:0] endOp;
  logic [LEN_W-1:0] endLen;

  always_comb begin
    st = '0;
    frameEnd = 1'b0;
    frameOk = 1'b0;
    endOp = capOp;
    endLen = capLen;
    lenOk = (hdrLen <= LEN_W'(MAX_LEN_BYTES)) && (hdrLen[1:0] == 2'b00);
    cntNext = {1'b0, beatCnt} + 1'b1;
    over = cntNext > {1'b0, expBeats};
    badNext = badQ | ~keepOk | over;
    if (beatFire) begin
      if (!inPayload) begin
        st.hdrLoad = 1'b1;
        endOp = hdrOp;
        endLen = hdrLen;
        if (inLast) begin
          frameEnd = 1'b1;
          frameOk = lenOk && keepOk && (hdrLen == '0);
        end
      end else begin
        st.word0Load = (beatCnt == '0);
        if (inLast) begin
          frameEnd = 1'b1;
          frameOk = !badNext && (cntNext == {1'b0, expBeats});
        end
      end
    end
    if (frameEnd) begin
      if (!frameOk) st.errPulse = 1'b1;
      else if (endOp == OP_CONFIG && endLen == LEN_W'(8)) st.cfgCommit = 1'b1;
      else if (endOp == OP_START && endLen == '0) st.streamOn = 1'b1;
      else if (endOp == OP_STOP && endLen == '0) st.streamOff = 1'b1;
      else st.dropPulse = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inPayload <= 1'b0;
      beatCnt <= '0;
      expBeats <= '0;
      badQ <= 1'b0;
    end else if (beatFire) begin
      if (!inPayload) begin
        inPayload <= !inLast;
        beatCnt <= '0;
        expBeats <= hdrLen[BEAT_W+1:2];
        badQ <= !lenOk || !keepOk || (hdrLen == '0);
      end else if (inLast) begin
        inPayload <= 1'b0;
      end else begin
        badQ <= badNext;
        if (!over) beatCnt <= cntNext[BEAT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/fcd_datapath.sv
module fcd_datapath
  import fcd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CHAN_W = 16,
  parameter int PERIOD_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   inData,
  input  fcdStrobes_t         st,
  output logic [DATA_W/2-1:0] capOp,
  output logic [DATA_W/2-1:0] capLen,
  output logic [CHAN_W-1:0]   chanCount,
  output logic [PERIOD_W-1:0] samplePeriod,
  output logic                streamEn,
  output logic                frameErr,
  output logic                frameDrop
);
  localparam int LEN_W = DATA_W / 2;

  logic [CHAN_W-1:0] word0Q;

  always_ff @(posedge clk) begin
    if (rst) begin
      capOp <= '0;
      capLen <= '0;
      word0Q <= '0;
      chanCount <= '0;
      samplePeriod <= '0;
      streamEn <= 1'b0;
      frameErr <= 1'b0;
      frameDrop <= 1'b0;
    end else begin
      if (st.hdrLoad) begin
        capOp <= inData[DATA_W-1:LEN_W];
        capLen <= inData[LEN_W-1:0];
      end
      if (st.word0Load) word0Q <= inData[CHAN_W-1:0];
      if (st.cfgCommit) begin
        chanCount <= word0Q;
        samplePeriod <= inData[PERIOD_W-1:0];
      end
      if (st.streamOn) streamEn <= 1'b1;
      else if (st.streamOff) streamEn <= 1'b0;
      frameErr <= st.errPulse;
      frameDrop <= st.dropPulse;
    end
  end
endmodule

// File: rtl/frame_cmd_decoder.sv
module frame_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CHAN_W = 16,
  parameter int PERIOD_W = 32,
  parameter int MAX_LEN_BYTES = 1024,
  parameter logic [15:0] OP_CONFIG = 16'h0052,
  parameter logic [15:0] OP_START = 16'h0054,
  parameter logic [15:0] OP_STOP = 16'h0055
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   inData,
  input  logic [DATA_W/8-1:0] inKeep,
  input  logic                inValid,
  input  logic                inLast,
  output logic                inReady,
  output logic [CHAN_W-1:0]   chanCount,
  output logic [PERIOD_W-1:0] samplePeriod,
  output logic                streamEn,
  output logic                frameErr,
  output logic                frameDrop
);
  localparam int LEN_W = DATA_W / 2;

  fcdStrobes_t st;
  logic beatFire;
  logic [LEN_W-1:0] capOp;
  logic [LEN_W-1:0] capLen;

  assign inReady = ~rst;
  assign beatFire = inValid & inReady;

  fcd_ctrl #(
    .LEN_W(LEN_W),
    .MAX_LEN_BYTES(MAX_LEN_BYTES),
    .OP_CONFIG(OP_CONFIG),
    .OP_START(OP_START),
    .OP_STOP(OP_STOP)
  ) u_ctrl (
    .clk(clk),
    .rst(rst),
    .beatFire(beatFire),
    .inLast(inLast),
    .keepOk(&inKeep),
    .hdrOp(inData[DATA_W-1:LEN_W]),
    .hdrLen(inData[LEN_W-1:0]),
    .capOp(capOp),
    .capLen(capLen),
    .st(st)
  );

  fcd_datapath #(
    .DATA_W(DATA_W),
    .CHAN_W(CHAN_W),
    .PERIOD_W(PERIOD_W)
  ) u_dp (
    .clk(clk),
    .rst(rst),
    .inData(inData),
    .st(st),
    .capOp(capOp),
    .capLen(capLen),
    .chanCount(chanCount),
    .samplePeriod(samplePeriod),
    .streamEn(streamEn),
    .frameErr(frameErr),
    .frameDrop(frameDrop)
  );
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int CHAN_W = 16,
  parameter int PERIOD_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                inValid,
  input logic                inLast,
  input logic                inReady,
  input logic [CHAN_W-1:0]   chanCount,
  input logic [PERIOD_W-1:0] samplePeriod,
  input logic                streamEn,
  input logic                frameErr,
  input logic                frameDrop
);
  AST_ERR_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    frameErr |-> $past(inValid && inReady && inLast)); // R6
  AST_DROP_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    frameDrop |-> $past(inValid && inReady && inLast)); // R9
  AST_ERR_KEEPS_SETTINGS: assert property (@(posedge clk) disable iff (rst)
    frameErr |-> ($stable(chanCount) && $stable(samplePeriod) && $stable(streamEn))); // R8
  AST_DROP_KEEPS_SETTINGS: assert property (@(posedge clk) disable iff (rst)
    frameDrop |-> ($stable(chanCount) && $stable(samplePeriod) && $stable(streamEn))); // R10
  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(frameErr && frameDrop)); // R11
  AST_QUIET_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    !$past(inValid && inReady && inLast) |->
      ($stable(chanCount) && $stable(samplePeriod) && $stable(streamEn))); // R5
endmodule

bind frame_cmd_decoder fcd_checker #(
  .CHAN_W(CHAN_W),
  .PERIOD_W(PERIOD_W)
) u_chk (
  .clk(clk),
  .rst(rst),
  .inValid(inValid),
  .inLast(inLast),
  .inReady(inReady),
  .chanCount(chanCount),
  .samplePeriod(samplePeriod),
  .streamEn(streamEn),
  .frameErr(frameErr),
  .frameDrop(frameDrop)
);

// File: tb/frame_cmd_decoder_tb.sv
`timescale 1ns/1ps
module frame_cmd_decoder_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] inData = '0;
  logic [3:0] inKeep = 4'hF;
  logic inValid = 1'b0;
  logic inLast = 1'b0;
  logic inReady;
  logic [15:0] chanCount;
  logic [31:0] samplePeriod;
  logic streamEn;
  logic frameErr;
  logic frameDrop;

  int checks = 0;
  int fails = 0;
  logic [15:0] mChan = '0;
  logic [31:0] mPer = '0;
  logic mEn = 1'b0;

  always #2.5 clk = ~clk;

  frame_cmd_decoder u_dut (
    .clk(clk), .rst(rst), .inData(inData), .inKeep(inKeep),
    .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .chanCount(chanCount), .samplePeriod(samplePeriod), .streamEn(streamEn),
    .frameErr(frameErr), .frameDrop(frameDrop)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // 1 = error, 2 = configure, 3 = start, 4 = stop, 5 = drop
  function automatic int expectKind(input logic [15:0] op, input int len, input int nPay, input bit badKeep);
    if (badKeep || len > 1024 || (len % 4) != 0 || nPay != len / 4) return 1;
    if (op == 16'h0052 && len == 8) return 2;
    if (op == 16'h0054 && len == 0) return 3;
    if (op == 16'h0055 && len == 0) return 4;
    return 5;
  endfunction

  task automatic putBeat(input logic [31:0] d, input logic [3:0] k, input bit last);
    int gaps;
    gaps = ($urandom % 4 == 0) ? int'($urandom % 3) : 0;
    for (int g = 0; g < gaps; g++) begin
      @(negedge clk);
      inValid = 1'b0; inData = $urandom; inLast = 1'($urandom); inKeep = 4'($urandom); // R5 idle garbage
    end
    @(negedge clk);
    inValid = 1'b1; inData = d; inKeep = k; inLast = last;
    @(posedge clk);
    #1;
  endtask

  task automatic sendFrame(input logic [15:0] op, input int len, input int nPay, input int badIdx,
                           input logic [31:0] w0, input logic [31:0] w1, input string req);
    int kind;
    logic [31:0] d;
    kind = expectKind(op, len, nPay, badIdx >= 0);
    putBeat({op, 16'(len)}, (badIdx == 0) ? 4'h7 : 4'hF, nPay == 0);
    for (int i = 0; i < nPay; i++) begin
      d = (i == 0) ? w0 : (i == 1) ? w1 : $urandom;
      putBeat(d, (badIdx == i + 1) ? 4'hB : 4'hF, i == nPay - 1);
    end
    case (kind)
      2: begin mChan = w0[15:0]; mPer = w1; end
      3: mEn = 1'b1;
      4: mEn = 1'b0;
      default: ;
    endcase
    check(frameErr == (kind == 1), {req, " frameErr"}, 32'(frameErr), 32'(kind == 1));
    check(frameDrop == (kind == 5), {req, " frameDrop"}, 32'(frameDrop), 32'(kind == 5));
    check(chanCount == mChan, {req, " chanCount"}, 32'(chanCount), 32'(mChan));
    check(samplePeriod == mPer, {req, " samplePeriod"}, samplePeriod, mPer);
    check(streamEn == mEn, {req, " streamEn"}, 32'(streamEn), 32'(mEn));
    @(negedge clk);
    inValid = 1'b0;
    @(posedge clk);
    #1;
    check(!frameErr && !frameDrop, {req, " R11 single-cycle pulse"}, {frameErr, frameDrop}, 32'h0);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] op;
    int len;
    int nPay;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check(inReady == 1'b0, "R1 ready low in reset", 32'(inReady), 32'h0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check(inReady == 1'b1, "R1 ready after reset", 32'(inReady), 32'h1);
    check({chanCount, samplePeriod, streamEn, frameErr, frameDrop} == '0, "R1 reset values",
          32'(chanCount) ^ samplePeriod, 32'h0);

    sendFrame(16'h0052, 8, 2, -1, 32'hABCD1234, 32'h0000_4E20, "R3 configure");
    sendFrame(16'h0054, 0, 0, -1, 0, 0, "R4 start");
    sendFrame(16'h0055, 0, 0, -1, 0, 0, "R4 stop");
    sendFrame(16'h0054, 0, 0, -1, 0, 0, "R4 start again");
    sendFrame(16'h0052, 8, 1, -1, 32'h1111_2222, 32'h3, "R6 early tlast");
    sendFrame(16'h0055, 4, 0, -1, 0, 0, "R6 tlast on header");
    sendFrame(16'h0052, 8, 3, -1, 32'h5555_6666, 32'h7, "R7 late tlast");
    sendFrame(16'h0055, 0, 2, -1, 0, 0, "R7 late on empty");
    sendFrame(16'h0055, 0, 0, -1, 0, 0, "R7 resync header");
    sendFrame(16'h0056, 1028, 257, -1, 0, 0, "R8 oversize");
    sendFrame(16'h0052, 6, 1, -1, 32'h9, 32'h9, "R8 unaligned");
    sendFrame(16'h0052, 8, 2, 2, 32'hAAAA_0042, 32'h99, "R8 partial keep");
    sendFrame(16'h0054, 0, 0, 0, 0, 0, "R8 partial keep header");
    sendFrame(16'h0056, 12, 3, -1, 0, 0, "R9 unknown opcode");
    sendFrame(16'h0052, 4, 1, -1, 32'h77, 0, "R10 configure len 4");
    sendFrame(16'h0052, 12, 3, -1, 32'h78, 32'h79, "R10 configure len 12");
    sendFrame(16'h0054, 4, 1, -1, 0, 0, "R10 start with payload");
    sendFrame(16'hBEEF, 1024, 256, -1, 0, 0, "R2 max length");
    sendFrame(16'h0052, 8, 2, -1, 32'h0001_0005, 32'hFFFF_FFFF, "R2 R3 configure after max");

    for (int n = 0; n < 60; n++) begin
      case ($urandom % 5)
        0: op = 16'h0052;
        1: op = 16'h0054;
        2: op = 16'h0055;
        3: op = 16'h0056;
        default: op = 16'($urandom);
      endcase
      case ($urandom % 7)
        0: len = 0;
        1: len = 4;
        2, 3: len = 8;
        4: len = 12;
        5: len = 4 * int'($urandom % 17);
        default: len = 6;
      endcase
      nPay = (len + 3) / 4;
      if ($urandom % 4 == 0) nPay = ($urandom % 2 == 0) ? nPay + 1 : ((nPay > 0) ? nPay - 1 : 1);
      sendFrame(op, len, nPay, ($urandom % 10 == 0) ? int'($urandom % (nPay + 1)) : -1,
                $urandom, $urandom, "R2 R5 random frame");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule